// File: doc/BRIEF.md
# Four-Channel DMA Request Front End

This block sits at the front of a four-channel DMA controller and decides which peripheral gets the bus next. Each channel's request line is asynchronous to the clock, so it passes through a synchronizer chain and then a programmable polarity stage. Hardware requests are gated by per-channel mask bits. Software request bits are added on top, and a fixed-priority picker chooses one channel, with channel 0 the highest.

Once a channel wins, the block raises a bus hold request toward the CPU. It waits for the hold grant and then drives a one-hot acknowledge and a transfer strobe for a single transfer. A low ready input stretches that strobe. After the transfer ends, the hold request is released.

A small CPU register port gives access to the command, mask, software request and status registers. It responds only while the block is idle.

Top module: `dma_req_frontend`

## Requirements
- R1: Reset (synchronous, active-high) clears the command register, the software request register and the status register, sets every mask bit, and returns the block to idle with `hold_req_o`, `ack_o` and `xfer_stb_o` low. Mask reads back as 0x0F at register address 1.
- R2: Each request line passes through two flip-flops. `hold_req_o` is still low after the second rising edge that follows a request change, and it is high after the third.
- R3: Command register bit 0 (address 0) selects the request polarity. 0 (the reset value) means active-high; 1 means a low level requests.
- R4: Register address 1, bits [3:0] form the mask; bit n masks channel n when 1. A masked hardware request never raises `hold_req_o`.
- R5: Register address 2, bits [3:0] are software requests; bit n requests channel n regardless of its mask bit. That bit clears when the channel's transfer completes.
- R6: When several channels are eligible, the lowest-numbered one is granted.
- R7: `ack_o` stays zero while the hold grant is low. It becomes the winner's one-hot code on the first rising edge at which `hold_gnt_i` is seen high in the hold state, and `xfer_stb_o` rises with it.
- R8: If the winning channel's request goes away before its acknowledge, the block returns to idle, `hold_req_o` falls, and no acknowledge is issued for it.
- R9: `ack_o` and `xfer_stb_o` stay asserted, unchanged, for every clock in which `rdy_i` is low. They fall on the first rising edge with `rdy_i` high.
- R10: `hold_req_o` is still high in the clock after the strobe falls and low one clock later.
- R11: Register reads and writes take effect only in the idle state. Writes issued while a request is being served leave every register unchanged.
- R12: Register address 3 is status. Bits [7:4] show, per channel, a live request (hardware masked or unmasked, or software). Bits [3:0] set when that channel's transfer completes. A status read returns the current value and clears bits [3:0].
- R13: `ack_o` is active-high and never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 4 | Asynchronous per-channel request lines |
| hold_req_o | output | 1 | Bus hold request to the CPU |
| hold_gnt_i | input | 1 | Bus hold grant from the CPU, active-high |
| rdy_i | input | 1 | Ready; low stretches the transfer strobe |
| ack_o | output | 4 | One-hot per-channel acknowledge |
| xfer_stb_o | output | 1 | Active-high transfer strobe |
| cpu_sel_n | input | 1 | Register port select, active-low |
| cpu_rd_n | input | 1 | Register read strobe, active-low |
| cpu_wr_n | input | 1 | Register write strobe, active-low |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check the following:
- the acknowledge is one-hot and only present under a hold request;
- the strobe rises only after a seen grant;
- the strobe and acknowledge hold steady while ready is low;
- the hold request trails the strobe by exactly one clock;
- a request lost in the hold state releases the hold;
- writes outside idle do not disturb the registers;
- a status read clears the completion bits.

Other behaviour only the bench scenarios can show: synchronizer latency, the priority choice under random masks and polarities, software request self-clearing, and the visible register contents after reset and after ignored writes.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } fe_state_t;

  localparam logic [1:0] RA_CMD   = 2'd0;
  localparam logic [1:0] RA_MASK  = 2'd1;
  localparam logic [1:0] RA_SWREQ = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CMD_POL_BIT = 0;

endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] raw_i,
  input  logic           low_active_i,
  output logic [NCH-1:0] act_o
);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], raw_i[ch]};
      end
      assign act_o[ch] = chain_q[STAGES-1] ^ low_active_i;
    end
  endgenerate

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NCH  = 4,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/fe_regs.sv
module fe_regs import dma_fe_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           access_ok_i,
  input  logic           sel_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] live_req_i,
  input  logic           done_i,
  input  logic [NCH-1:0] done_ch_i,
  output logic           pol_low_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] swreq_o
);

  logic [DW-1:0]  cmd_q;
  logic [NCH-1:0] mask_q, sw_q, tc_q, pend_q;
  logic [DW-1:0]  rd_mux;
  logic           wr_en, rd_en;

  assign wr_en = access_ok_i && !sel_n && !wr_n;
  assign rd_en = access_ok_i && !sel_n && !rd_n;

  always_comb begin
    rd_mux = '0;
    case (addr[1:0])
      RA_CMD:   rd_mux = cmd_q;
      RA_MASK:  rd_mux[NCH-1:0] = mask_q;
      RA_SWREQ: rd_mux[NCH-1:0] = sw_q;
      default: begin
        rd_mux[2*NCH-1:NCH] = pend_q;
        rd_mux[NCH-1:0]     = tc_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      mask_q  <= '1;
      sw_q    <= '0;
      tc_q    <= '0;
      pend_q  <= '0;
      rdata_o <= '0;
    end else begin
      pend_q <= live_req_i;
      if (wr_en && addr[1:0] == RA_CMD)  cmd_q  <= wdata;
      if (wr_en && addr[1:0] == RA_MASK) mask_q <= wdata[NCH-1:0];
      if (done_i) begin
        sw_q <= sw_q & ~done_ch_i;
        tc_q <= tc_q | done_ch_i;
      end else if (wr_en && addr[1:0] == RA_SWREQ) begin
        sw_q <= wdata[NCH-1:0];
      end
      if (rd_en) begin
        rdata_o <= rd_mux;
        if (addr[1:0] == RA_STAT && !done_i) tc_q <= '0;
      end
    end
  end

  assign pol_low_o = cmd_q[CMD_POL_BIT];
  assign mask_o    = mask_q;
  assign swreq_o   = sw_q;

  // R1: reset leaves every channel masked
  p_mask_reset_r1: assert property (@(posedge clk) rst |=> (mask_q == '1 && cmd_q == '0));

  // R11: a write attempt outside idle leaves mask and command unchanged
  p_busy_write_r11: assert property (@(posedge clk) disable iff (rst)
    (!access_ok_i && !sel_n && !wr_n) |=> ($stable(mask_q) && $stable(cmd_q)));

  // R12: reading status in idle clears the completion bits
  p_stat_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[1:0] == RA_STAT && !done_i) |=> (tc_q == '0));

endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend import dma_fe_pkg::*; #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8,
  parameter int AW          = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_in,
  output logic           hold_req_o,
  input  logic           hold_gnt_i,
  input  logic           rdy_i,
  output logic [NCH-1:0] ack_o,
  output logic           xfer_stb_o,
  input  logic           cpu_sel_n,
  input  logic           cpu_rd_n,
  input  logic           cpu_wr_n,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata
);

  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

  fe_state_t      st_q;
  logic [IDXW-1:0] win_q, pick_idx;
  logic           pick_any;
  logic [NCH-1:0] hw_act, elig, mask, swreq;
  logic           pol_low, done;

  req_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(req_in), .low_active_i(pol_low), .act_o(hw_act)
  );

  assign elig = (hw_act & ~mask) | swreq;

  prio_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .req_i(elig), .any_o(pick_any), .idx_o(pick_idx)
  );

  assign done = (st_q == ST_XFER) && rdy_i;

  fe_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .access_ok_i(st_q == ST_IDLE),
    .sel_n(cpu_sel_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n),
    .addr(cpu_addr), .wdata(cpu_wdata), .rdata_o(cpu_rdata),
    .live_req_i(hw_act | swreq), .done_i(done), .done_ch_i(ack_o),
    .pol_low_o(pol_low), .mask_o(mask), .swreq_o(swreq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      win_q      <= '0;
      hold_req_o <= 1'b0;
      ack_o      <= '0;
      xfer_stb_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (pick_any) begin
          win_q      <= pick_idx;
          hold_req_o <= 1'b1;
          st_q       <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!elig[win_q]) begin
            hold_req_o <= 1'b0;
            st_q       <= ST_IDLE;
          end else if (hold_gnt_i) begin
            ack_o      <= NCH'(1) << win_q;
            xfer_stb_o <= 1'b1;
            st_q       <= ST_XFER;
          end
        end
        ST_XFER: if (rdy_i) begin
          ack_o      <= '0;
          xfer_stb_o <= 1'b0;
          st_q       <= ST_DONE;
        end
        default: begin
          hold_req_o <= 1'b0;
          st_q       <= ST_IDLE;
        end
      endcase
    end
  end

  // R13: at most one acknowledge at a time
  p_ack_onehot_r13: assert property (@(posedge clk) disable iff (rst) $onehot0(ack_o));
  // R7: an acknowledge is only present under a hold request
  p_ack_in_hold_r7: assert property (@(posedge clk) disable iff (rst) (|ack_o) |-> hold_req_o);
  // R7: the strobe starts only after a grant was seen
  p_stb_after_gnt_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_stb_o) |-> $past(hold_gnt_i));
  // R9: ready low keeps strobe and acknowledge steady
  p_stretch_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb_o && !rdy_i) |=> (xfer_stb_o && $stable(ack_o)));
  // R10: hold request outlives the strobe by one clock
  p_hold_tail_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_stb_o) |-> hold_req_o);
  p_hold_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_stb_o) |=> !hold_req_o);
  // R8: a lost request in the hold state releases the hold without acknowledge
  p_discard_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && !elig[win_q]) |=> (!hold_req_o && ack_o == '0));

endmodule

// File: tb/dma_req_frontend_tb.sv
module dma_req_frontend_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic [NCH-1:0] req_in = '0;
  logic           hold_req_o, hold_gnt_i = 1'b0, rdy_i = 1'b1, xfer_stb_o;
  logic [NCH-1:0] ack_o;
  logic           cpu_sel_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [1:0]     cpu_addr = '0;
  logic [7:0]     cpu_wdata = '0, cpu_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  dma_req_frontend dut_i (
    .clk(clk), .rst(rst), .req_in(req_in), .hold_req_o(hold_req_o),
    .hold_gnt_i(hold_gnt_i), .rdy_i(rdy_i), .ack_o(ack_o), .xfer_stb_o(xfer_stb_o),
    .cpu_sel_n(cpu_sel_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [3:0] lowest_bit(input logic [3:0] v);
    return v & (~v + 4'd1);
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_sel_n = 1'b0; cpu_wr_n = 1'b0;
    step(1);
    cpu_sel_n = 1'b1; cpu_wr_n = 1'b1;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_sel_n = 1'b0; cpu_rd_n = 1'b0;
    step(1);
    d = cpu_rdata;
    cpu_sel_n = 1'b1; cpu_rd_n = 1'b1;
  endtask

  task automatic do_xfer(input logic [3:0] drive, input logic [3:0] idle_lvl,
                         input logic [3:0] exp_oh, input int waits);
    req_in = drive;
    step(2);
    chk("R2", "hold after two edges", 32'(hold_req_o), 0);
    step(1);
    chk("R2", "hold after three edges", 32'(hold_req_o), 1);
    step(1);
    chk("R7", "no ack without grant", 32'(ack_o), 0);
    hold_gnt_i = 1'b1;
    step(1);
    chk("R6", "granted channel", 32'(ack_o), 32'(exp_oh));
    chk("R7", "strobe with ack", 32'(xfer_stb_o), 1);
    req_in = idle_lvl;
    rdy_i = (waits == 0);
    for (int i = 0; i < waits; i++) begin
      step(1);
      chk("R9", "stretched strobe", 32'({xfer_stb_o, ack_o}), 32'({1'b1, exp_oh}));
    end
    rdy_i = 1'b1;
    step(1);
    chk("R9", "strobe end", 32'({xfer_stb_o, ack_o}), 0);
    chk("R10", "hold tail", 32'(hold_req_o), 1);
    step(1);
    chk("R10", "hold released", 32'(hold_req_o), 0);
    hold_gnt_i = 1'b0;
    step(3);
  endtask

  initial begin
    logic [7:0] rd;
    int seed_set;
    seed_set = $urandom(32'h5EED_0042);
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1", "outputs after reset", 32'({hold_req_o, xfer_stb_o, ack_o}), 0);
    cpu_read(2'd0, rd); chk("R1", "command", 32'(rd), 0);
    cpu_read(2'd1, rd); chk("R1", "mask", 32'(rd), 32'h0F);
    cpu_read(2'd2, rd); chk("R1", "soft request", 32'(rd), 0);
    cpu_read(2'd3, rd); chk("R1", "status", 32'(rd), 0);

    // R4 masked requests ignored, R12 pending still shown
    req_in = 4'b0101;
    step(5);
    chk("R4", "masked request no hold", 32'(hold_req_o), 0);
    cpu_read(2'd3, rd); chk("R12", "pending while masked", 32'(rd), 32'h50);
    req_in = '0;
    step(3);

    // R6 priority with two requests
    cpu_write(2'd1, 8'h00);
    do_xfer(4'b0110, 4'b0000, 4'b0010, 2);
    cpu_read(2'd3, rd); chk("R12", "completion bit", 32'(rd), 32'h02);
    cpu_read(2'd3, rd); chk("R12", "completion cleared by read", 32'(rd), 32'h00);

    // R11 writes ignored while serving
    req_in = 4'b1000;
    step(3);
    chk("R11", "hold before busy write", 32'(hold_req_o), 1);
    cpu_write(2'd1, 8'h0F);
    cpu_write(2'd0, 8'h01);
    hold_gnt_i = 1'b1;
    step(1);
    chk("R11", "ack for ch3", 32'(ack_o), 32'h8);
    req_in = '0;
    step(1);
    step(1);
    hold_gnt_i = 1'b0;
    step(3);
    cpu_read(2'd1, rd); chk("R11", "mask unchanged", 32'(rd), 32'h00);
    cpu_read(2'd0, rd); chk("R11", "command unchanged", 32'(rd), 32'h00);
    cpu_read(2'd3, rd);

    // R8 discard
    req_in = 4'b0100;
    step(3);
    chk("R8", "hold raised", 32'(hold_req_o), 1);
    req_in = '0;
    step(3);
    chk("R8", "hold dropped after loss", 32'(hold_req_o), 0);
    hold_gnt_i = 1'b1;
    step(2);
    chk("R8", "no ack for lost request", 32'(ack_o), 0);
    hold_gnt_i = 1'b0;
    step(2);

    // R5 soft request bypasses mask and self-clears
    cpu_write(2'd1, 8'h0F);
    cpu_write(2'd2, 8'h08);
    step(1);
    chk("R5", "soft request hold", 32'(hold_req_o), 1);
    hold_gnt_i = 1'b1;
    step(1);
    chk("R5", "soft request ack", 32'(ack_o), 32'h8);
    step(1);
    step(1);
    hold_gnt_i = 1'b0;
    step(2);
    cpu_read(2'd2, rd); chk("R5", "soft request cleared", 32'(rd), 0);
    cpu_read(2'd3, rd); chk("R12", "status after soft", 32'(rd), 32'h08);

    // R3 active-low polarity
    cpu_write(2'd0, 8'h01);
    req_in = 4'hF;
    step(3);
    cpu_write(2'd1, 8'h00);
    step(5);
    chk("R3", "high level idle when active-low", 32'(hold_req_o), 0);
    do_xfer(4'b1011, 4'hF, 4'b0100, 1);
    cpu_read(2'd3, rd);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [3:0] msk, pat, idle_lvl;
      logic       pol;
      int         w;
      pol = 1'($urandom % 2);
      do begin
        msk = 4'($urandom);
        pat = 4'($urandom);
      end while ((pat & ~msk) == 4'd0);
      w = int'($urandom % 4);
      idle_lvl = pol ? 4'hF : 4'h0;
      cpu_write(2'd1, 8'h0F);
      cpu_write(2'd0, {7'd0, pol});
      req_in = idle_lvl;
      step(3);
      cpu_write(2'd1, {4'd0, msk});
      do_xfer(pol ? ~pat : pat, idle_lvl, lowest_bit(pat & ~msk), w);
      cpu_read(2'd3, rd);
      chk("R12", "random status", 32'(rd), 32'({4'd0, lowest_bit(pat & ~msk)}));
      chk("R13", "ack idle", 32'(ack_o), 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule